// File: doc/BRIEF.md
# Burst and Drain Traffic Generator

This block is a synthesizable stimulus engine for sizing and stressing a FIFO. It produces the worst-case enable pattern. The producer side writes on every cycle of a burst. The consumer side reads once per completed read interval. A start pulse launches one sequence, which runs one or more bursts and then a drain tail. During the drain tail the producer is idle and the consumer keeps its cadence.

The cadence is phase-locked to each phase. A read fires only once a full read interval has elapsed inside the current burst or drain window, so the first read of a phase never lands on its first cycle. Write data during a burst is the cycle index within that burst, which gives a known ascending sequence at the consumer. An optional duty-cycle mode thins the producer to a fixed number of valid cycles per period. A burst count above one chains bursts back to back, with no gap and no drain between them.

The FIFO's full flag may be fed back. The block then counts the writes that the FIFO refused, so a run shows whether a chosen depth survives the pattern.

Top module: `burst_drain_gen`

## Requirements
- R1: A synchronous active-high reset returns the block to idle within one clock edge. After that edge, wr_en, rd_en, busy and done are low, and wr_data and drop_count are zero. This also holds when reset arrives in the middle of a sequence.
- R2: When start is high at a clock edge while busy is low, the next cycle is burst cycle 0 and busy rises. A burst lasts exactly L cycles, where L is cfg_burst_len and a value of 0 means 1. With duty mode off, wr_en is high on every burst cycle.
- R3: Inside each burst and inside the drain, let t be the 0-based cycle index within that phase. rd_en is high exactly when (t+1) mod R equals 0, where R is cfg_rd_every. The index t restarts at the start of every burst and at the start of the drain. An R of 0 or 1 means a read on every cycle.
- R4: On burst cycle t, wr_data equals t mod 2^DATA_W. Outside burst cycles, wr_data is zero.
- R5: With cfg_duty_en high, wr_en is high on burst cycle t only when (t mod P) < W. Here W is cfg_duty_on and P is cfg_duty_period, and a P of 0 means 1.
- R6: cfg_burst_count sets N bursts, and a value of 0 means 1. Each burst starts on the cycle right after the previous one ends. There is no idle cycle and no drain between bursts.
- R7: After the last burst there is a drain of L cycles with wr_en low. The next cycle has done high for exactly one cycle with busy, wr_en and rd_en low. The cycle after that has done low.
- R8: A start pulse while busy is high has no effect. All configuration inputs are sampled only at the accepting edge, and later changes do not alter the running sequence.
- R9: drop_count is cleared when a start is accepted. It increments on each clock edge where wr_en and fifo_full are both high, and it saturates at 2^DROP_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches a sequence when idle |
| cfg_burst_len | input | LEN_W | Burst and drain length in cycles |
| cfg_rd_every | input | IVL_W | Read interval in cycles |
| cfg_duty_en | input | 1 | Enables duty-cycle gating of writes |
| cfg_duty_on | input | DUTY_W | Valid write cycles per period |
| cfg_duty_period | input | DUTY_W | Duty period in cycles |
| cfg_burst_count | input | CNT_W | Number of back-to-back bursts |
| fifo_full | input | 1 | Full flag of the FIFO under test |
| wr_en | output | 1 | Producer write enable |
| wr_data | output | DATA_W | Producer write data |
| rd_en | output | 1 | Consumer read enable |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle end-of-sequence pulse |
| drop_count | output | DROP_W | Refused writes in the current run |

## Verification
Directed runs cover these cases:
- A burst of 12 with a read every third cycle checks the delayed first read and the per-phase cadence.
- Read intervals of 0 and 1 separate the every-cycle case from an off-by-one in the modulus.
- Zero and unit burst lengths check the clamping.
- A triple back-to-back run shows whether the cadence and data index restart at each burst with no gap.
- Duty patterns with W below, at and above P, plus W of zero, separate the gating compare from the period wrap.

Random configurations cover the rest, with each cycle checked against a bench model:
- The configuration inputs are scrambled every cycle, and start is re-pulsed mid-run, to expose any late sampling.
- Random and constant full flags check refused-write counting.
- A long burst into an always-full FIFO checks saturation.
- A reset in mid-run checks the return to idle.

// File: rtl/bdg_pkg.sv
package bdg_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_BURST = 2'd1,
    PH_DRAIN = 2'd2
  } bdg_phase_e;
endpackage

// File: rtl/bdg_mod_ctr.sv
// Modulo counter with restart; exposes its next value so the owner can
// register decoded outputs in the same edge as the state.
module bdg_mod_ctr #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          advance,
  input  logic [CW-1:0] modulus,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_nxt
);
  always_comb begin
    cnt_nxt = cnt_q;
    if (restart) begin
      cnt_nxt = '0;
    end else if (advance) begin
      if (cnt_q >= modulus - 1'b1) cnt_nxt = '0;
      else                         cnt_nxt = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/bdg_seq.sv
// Phase sequencer: bursts (chained without gap), then a drain, then idle.
module bdg_seq
  import bdg_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_acc,
  input  logic [LEN_W-1:0] len,
  input  logic [CNT_W-1:0] bursts,
  output bdg_phase_e       phase_q,
  output bdg_phase_e       phase_nxt,
  output logic [LEN_W-1:0] t_nxt,
  output logic             restart,
  output logic             advance,
  output logic             finish
);
  logic [LEN_W-1:0] t_q;
  logic [CNT_W-1:0] left_q, left_nxt;
  logic             last_cyc;

  assign last_cyc = (t_q >= len - 1'b1);

  always_comb begin
    phase_nxt = phase_q;
    t_nxt     = t_q;
    left_nxt  = left_q;
    restart   = 1'b0;
    advance   = 1'b0;
    finish    = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (start_acc) begin
          phase_nxt = PH_BURST;
          t_nxt     = '0;
          left_nxt  = bursts - 1'b1;
          restart   = 1'b1;
        end
      end
      PH_BURST: begin
        if (last_cyc) begin
          t_nxt   = '0;
          restart = 1'b1;
          if (left_q != '0) left_nxt  = left_q - 1'b1;
          else              phase_nxt = PH_DRAIN;
        end else begin
          t_nxt   = t_q + 1'b1;
          advance = 1'b1;
        end
      end
      PH_DRAIN: begin
        if (last_cyc) begin
          phase_nxt = PH_IDLE;
          t_nxt     = '0;
          restart   = 1'b1;
          finish    = 1'b1;
        end else begin
          t_nxt   = t_q + 1'b1;
          advance = 1'b1;
        end
      end
      default: begin
        phase_nxt = PH_IDLE;
        t_nxt     = '0;
        left_nxt  = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      t_q     <= '0;
      left_q  <= '0;
    end else begin
      phase_q <= phase_nxt;
      t_q     <= t_nxt;
      left_q  <= left_nxt;
    end
  end
endmodule

// File: rtl/bdg_drop_ctr.sv
// Saturating count of writes presented while the FIFO reported full.
module bdg_drop_ctr #(
  parameter int DROP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              hit,
  output logic [DROP_W-1:0] cnt
);
  localparam logic [DROP_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst || clear)                cnt <= '0;
    else if (hit && cnt != CNT_MAX)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/burst_drain_gen.sv
module burst_drain_gen
  import bdg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 8,
  parameter int IVL_W  = 4,
  parameter int DUTY_W = 4,
  parameter int CNT_W  = 3,
  parameter int DROP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LEN_W-1:0]  cfg_burst_len,
  input  logic [IVL_W-1:0]  cfg_rd_every,
  input  logic              cfg_duty_en,
  input  logic [DUTY_W-1:0] cfg_duty_on,
  input  logic [DUTY_W-1:0] cfg_duty_period,
  input  logic [CNT_W-1:0]  cfg_burst_count,
  input  logic              fifo_full,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_en,
  output logic              busy,
  output logic              done,
  output logic [DROP_W-1:0] drop_count
);
  typedef struct packed {
    logic [LEN_W-1:0]  len;
    logic [IVL_W-1:0]  ivl;
    logic              duty_en;
    logic [DUTY_W-1:0] duty_on;
    logic [DUTY_W-1:0] duty_per;
    logic [CNT_W-1:0]  nburst;
  } cfg_t;

  cfg_t             cfg_q, cfg_in, cfg_nxt;
  bdg_phase_e       phase_q, phase_nxt;
  logic [LEN_W-1:0] t_nxt;
  logic             seq_restart, seq_advance, seq_finish;
  logic             start_acc;
  logic [IVL_W-1:0]  rc_q, rc_nxt;
  logic [DUTY_W-1:0] dc_q, dc_nxt;
  logic [DATA_W-1:0] t_as_data;
  logic              wr_n, rd_n;

  assign start_acc = start && (phase_q == PH_IDLE);

  // Zero-valued lengths, intervals, periods and counts act as one.
  always_comb begin
    cfg_in.len      = (cfg_burst_len   == '0) ? LEN_W'(1)  : cfg_burst_len;
    cfg_in.ivl      = (cfg_rd_every    == '0) ? IVL_W'(1)  : cfg_rd_every;
    cfg_in.duty_en  = cfg_duty_en;
    cfg_in.duty_on  = cfg_duty_on;
    cfg_in.duty_per = (cfg_duty_period == '0) ? DUTY_W'(1) : cfg_duty_period;
    cfg_in.nburst   = (cfg_burst_count == '0) ? CNT_W'(1)  : cfg_burst_count;
    cfg_nxt         = start_acc ? cfg_in : cfg_q;
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else     cfg_q <= cfg_nxt;
  end

  bdg_seq #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start_acc (start_acc),
    .len       (cfg_nxt.len),
    .bursts    (cfg_nxt.nburst),
    .phase_q   (phase_q),
    .phase_nxt (phase_nxt),
    .t_nxt     (t_nxt),
    .restart   (seq_restart),
    .advance   (seq_advance),
    .finish    (seq_finish)
  );

  // Read cadence, restarted at every phase boundary.
  bdg_mod_ctr #(.CW(IVL_W)) u_rd_cad (
    .clk     (clk),
    .rst     (rst),
    .restart (seq_restart),
    .advance (seq_advance),
    .modulus (cfg_nxt.ivl),
    .cnt_q   (rc_q),
    .cnt_nxt (rc_nxt)
  );

  // Position inside the producer duty period.
  bdg_mod_ctr #(.CW(DUTY_W)) u_duty_pos (
    .clk     (clk),
    .rst     (rst),
    .restart (seq_restart),
    .advance (seq_advance),
    .modulus (cfg_nxt.duty_per),
    .cnt_q   (dc_q),
    .cnt_nxt (dc_nxt)
  );

  generate
    if (DATA_W > LEN_W) begin : g_data_ext
      assign t_as_data = {{(DATA_W-LEN_W){1'b0}}, t_nxt};
    end else if (DATA_W == LEN_W) begin : g_data_eq
      assign t_as_data = t_nxt;
    end else begin : g_data_trunc
      assign t_as_data = t_nxt[DATA_W-1:0];
    end
  endgenerate

  assign wr_n = (phase_nxt == PH_BURST) &&
                (!cfg_nxt.duty_en || (dc_nxt < cfg_nxt.duty_on));
  assign rd_n = (phase_nxt != PH_IDLE) && (rc_nxt == cfg_nxt.ivl - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      wr_data <= '0;
      rd_en   <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      wr_en   <= wr_n;
      wr_data <= (phase_nxt == PH_BURST) ? t_as_data : '0;
      rd_en   <= rd_n;
      busy    <= (phase_nxt != PH_IDLE);
      done    <= seq_finish;
    end
  end

  bdg_drop_ctr #(.DROP_W(DROP_W)) u_drop (
    .clk   (clk),
    .rst   (rst),
    .clear (start_acc),
    .hit   (wr_en && fifo_full),
    .cnt   (drop_count)
  );
endmodule

// File: rtl/bdg_checker.sv
module bdg_checker #(
  parameter int DATA_W = 8,
  parameter int DROP_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_en,
  input logic              busy,
  input logic              done,
  input logic [DROP_W-1:0] drop_count
);
  // R1: reset leaves the outputs quiet.
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!busy && !wr_en && !rd_en && !done && drop_count == '0));

  // R2: an idle start launches a sequence.
  a_r2_start_launch: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R2: no enable outside a running sequence.
  a_r2_enables_in_run: assert property (@(posedge clk) disable iff (rst)
    (wr_en || rd_en) |-> busy);

  // R4: data is zero outside bursts.
  a_r4_data_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (wr_data == '0));

  // R7: done is a single-cycle pulse.
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7: done follows a running sequence and coincides with idle.
  a_r7_done_after_run: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  // R9: the refused-write count steps by at most one unless a run restarts.
  a_r9_drop_step: assert property (@(posedge clk) disable iff (rst)
    !(start && !busy) |=>
      ((drop_count == $past(drop_count)) ||
       ({1'b0, drop_count} == {1'b0, $past(drop_count)} + 1'b1)));
endmodule

bind burst_drain_gen bdg_checker #(.DATA_W(DATA_W), .DROP_W(DROP_W)) u_bdg_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .rd_en      (rd_en),
  .busy       (busy),
  .done       (done),
  .drop_count (drop_count)
);

// File: tb/test_burst_drain_gen.sv
module test_burst_drain_gen;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 4;
  localparam int LEN_W  = 8;
  localparam int IVL_W  = 4;
  localparam int DUTY_W = 4;
  localparam int CNT_W  = 3;
  localparam int DROP_W = 5;
  localparam int DROP_MAX = (1 << DROP_W) - 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [LEN_W-1:0]  cfg_burst_len = '0;
  logic [IVL_W-1:0]  cfg_rd_every = '0;
  logic              cfg_duty_en = 1'b0;
  logic [DUTY_W-1:0] cfg_duty_on = '0;
  logic [DUTY_W-1:0] cfg_duty_period = '0;
  logic [CNT_W-1:0]  cfg_burst_count = '0;
  logic              fifo_full = 1'b0;
  logic              wr_en, rd_en, busy, done;
  logic [DATA_W-1:0] wr_data;
  logic [DROP_W-1:0] drop_count;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_drain_gen #(
    .DATA_W(DATA_W), .LEN_W(LEN_W), .IVL_W(IVL_W),
    .DUTY_W(DUTY_W), .CNT_W(CNT_W), .DROP_W(DROP_W)
  ) i_burst_drain_gen (
    .clk(clk), .rst(rst), .start(start),
    .cfg_burst_len(cfg_burst_len), .cfg_rd_every(cfg_rd_every),
    .cfg_duty_en(cfg_duty_en), .cfg_duty_on(cfg_duty_on),
    .cfg_duty_period(cfg_duty_period), .cfg_burst_count(cfg_burst_count),
    .fifo_full(fifo_full), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .busy(busy), .done(done), .drop_count(drop_count)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  task automatic scramble_cfg();
    cfg_burst_len   = LEN_W'($urandom);
    cfg_rd_every    = IVL_W'($urandom);
    cfg_duty_en     = 1'($urandom);
    cfg_duty_on     = DUTY_W'($urandom);
    cfg_duty_period = DUTY_W'($urandom);
    cfg_burst_count = CNT_W'($urandom);
  endtask

  // One full sequence checked cycle by cycle against the requirement model.
  // fmode: 0 never full, 1 always full, 2 random full.
  task automatic run_seq(input int L, input int R, input bit de, input int W,
                         input int P, input int N, input int fmode, input bit poke);
    int le, re, pe, ne, nb, total, idx, t, drops, ed;
    bit ew, er, fnow;
    string tw, tr, td, tb;
    le = (L == 0) ? 1 : L;
    re = (R == 0) ? 1 : R;
    pe = (P == 0) ? 1 : P;
    ne = (N == 0) ? 1 : N;
    nb = ne * le;
    total = nb + le;
    tw = poke ? "R8" : (de ? "R5" : (ne > 1 ? "R6" : "R2"));
    tr = poke ? "R8" : "R3";
    td = poke ? "R8" : "R4";
    tb = poke ? "R8" : "R7";
    @(negedge clk);
    cfg_burst_len   = LEN_W'(L);
    cfg_rd_every    = IVL_W'(R);
    cfg_duty_en     = de;
    cfg_duty_on     = DUTY_W'(W);
    cfg_duty_period = DUTY_W'(P);
    cfg_burst_count = CNT_W'(N);
    fifo_full = 1'b0;
    start = 1'b1;
    drops = 0;
    @(negedge clk);
    for (int c = 1; c <= total + 1; c++) begin
      idx = c - 1;
      ew = 1'b0; er = 1'b0; ed = 0;
      if (idx < nb) begin
        t  = idx % le;
        ew = !de || ((t % pe) < W);
        er = ((t + 1) % re) == 0;
        ed = t % (1 << DATA_W);
      end else if (idx < total) begin
        t  = idx - nb;
        er = ((t + 1) % re) == 0;
      end
      chk(tw, "wr_en", int'(wr_en), int'(ew));
      chk(tr, "rd_en", int'(rd_en), int'(er));
      chk(td, "wr_data", int'(wr_data), ed);
      chk(tb, "busy", int'(busy), int'(idx < total));
      chk(tb, "done", int'(done), int'(idx == total));
      if (idx == total) chk("R9", "drop_count", int'(drop_count), drops);
      fnow = (fmode == 1) ? 1'b1 : ((fmode == 2) ? 1'($urandom) : 1'b0);
      fifo_full = fnow;
      start = poke && (c == 2);
      scramble_cfg();
      if (ew && fnow && drops < DROP_MAX) drops++;
      @(negedge clk);
    end
    fifo_full = 1'b0;
    start = 1'b0;
    chk(tb, "busy after done", int'(busy), 0);
    chk(tb, "done one cycle", int'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int unsigned seed_sink;
    seed_sink = $urandom(32'd20240611);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "wr_en", int'(wr_en), 0);
    chk("R1", "rd_en", int'(rd_en), 0);
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "done", int'(done), 0);
    chk("R1", "wr_data", int'(wr_data), 0);
    chk("R1", "drop_count", int'(drop_count), 0);
    rst = 1'b0;

    // Directed corners
    run_seq(12, 3, 1'b0, 0, 0, 1, 0, 1'b0);  // R3 delayed first read
    run_seq(7, 1, 1'b0, 0, 0, 1, 0, 1'b0);   // R3 every cycle
    run_seq(5, 0, 1'b0, 0, 0, 1, 0, 1'b0);   // R3 zero interval
    run_seq(0, 2, 1'b0, 0, 0, 1, 0, 1'b0);   // R2 zero length
    run_seq(1, 3, 1'b0, 0, 0, 1, 0, 1'b0);   // R7 unit length
    run_seq(6, 4, 1'b0, 0, 0, 3, 0, 1'b0);   // R6 back to back
    run_seq(20, 3, 1'b0, 0, 0, 1, 0, 1'b0);  // R4 data wrap past 2^DATA_W
    run_seq(10, 2, 1'b1, 2, 3, 1, 0, 1'b0);  // R5 W<P
    run_seq(8, 2, 1'b1, 0, 3, 1, 0, 1'b0);   // R5 W=0
    run_seq(8, 2, 1'b1, 5, 4, 2, 0, 1'b0);   // R5 W>P
    run_seq(9, 3, 1'b1, 1, 0, 1, 0, 1'b0);   // R5 P=0
    run_seq(10, 3, 1'b0, 0, 0, 2, 2, 1'b1);  // R8 start while busy
    run_seq(40, 5, 1'b0, 0, 0, 1, 1, 1'b0);  // R9 saturation

    // R1: reset in mid-run
    @(negedge clk);
    cfg_burst_len = 8'd10; cfg_rd_every = 4'd2; cfg_duty_en = 1'b0;
    cfg_burst_count = 3'd1; fifo_full = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1", "mid wr_en", int'(wr_en), 0);
    chk("R1", "mid rd_en", int'(rd_en), 0);
    chk("R1", "mid busy", int'(busy), 0);
    chk("R1", "mid wr_data", int'(wr_data), 0);
    chk("R1", "mid drop_count", int'(drop_count), 0);
    rst = 1'b0;
    fifo_full = 1'b0;

    // Constrained random sequences
    for (int k = 0; k < 40; k++) begin
      run_seq($urandom_range(0, 20), $urandom_range(0, 6), 1'($urandom),
              $urandom_range(0, 5), $urandom_range(0, 6), $urandom_range(0, 3),
              $urandom_range(0, 2), 1'($urandom_range(0, 3) == 0));
    end
    report();
  end
endmodule